// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block counts clock cycles and selected hardware events for profiling. It holds one 32-bit cycle counter and four 32-bit event counters. Each event counter watches one line of a 128-wide event bus, and software picks that line through a per-counter event type. Software reaches all state through a small register port. To get a sample every N occurrences, software loads a counter with the two's complement of N. When the counter wraps it sets a sticky overflow flag, and the flag can drive a level interrupt.

The event counters are reached indirectly. A select register names one event counter, and the event type and event count addresses then act on that counter only. The cycle counter has an address of its own. Counter enables and interrupt enables each have a set address and a clear address, so that software never has to do a read-modify-write. The cycle counter can run at full rate, or it can advance once every 64 enabled clocks.

Top module: `pmu_monitor`

Register addresses (bus_addr): 0 control, 1 enable-set, 2 enable-clear, 3 interrupt-enable-set, 4 interrupt-enable-clear, 5 overflow flags, 6 select, 7 event type, 8 event count, 9 cycle count. Any other address reads as zero. In the mask registers (1 to 5), bit 31 stands for the cycle counter and bits 3:0 stand for event counters 0 to 3.

## Requirements
- R1: After a synchronous active-low reset, every register reads as zero and irq is low.
- R2: Control (address 0): bit 0 is the global enable and bit 3 selects divide-by-64 for the cycle counter. Bits 4 and 5 are stored and read back. Bits 1 and 2 are one-shot actions that always read as 0. Bits 31:6 read as 0.
- R3: A counter advances on a clock edge only if, before that edge, the global enable and its own enable bit are both 1. An event counter also needs the event_in line named by its 7-bit event type to be high in that cycle.
- R4: Writing 1 to a bit at address 1 enables that counter, and writing 1 at address 2 disables it. Zero bits have no effect. Both addresses read back the current enable mask. Bits 30:4 are ignored on write and read as 0.
- R5: Writing control bit 1 zeroes all event counters. Writing control bit 2 zeroes the cycle counter and its 64-clock prescaler. Neither action touches the other kind of counter.
- R6: With bit 3 set, the cycle counter advances once per 64 enabled clocks. The first step comes on the 64th enabled edge after the prescaler was last cleared.
- R7: A counter that advances from 0xFFFFFFFF wraps to 0 and sets its flag bit at address 5 on the same edge. Writing 1 to a flag bit clears it. Writing 0 leaves it set.
- R8: irq is high exactly when some counter has both its flag and its interrupt enable set. Interrupt enables are set at address 3, cleared at address 4 (write 1 to act), and read back at both addresses.
- R9: The select register (address 6) keeps 5 bits. Addresses 7 and 8 reach the event type (masked to 7 bits) and the count of the selected event counter. When select is above 3, those addresses read 0 and ignore writes.
- R10: Address 9 reads and writes the cycle counter directly, whatever select holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| event_in | input | 128 | Event lines, one count per high cycle |
| irq | output | 1 | Level overflow interrupt |

## Verification
The event counter is driven in three ways: with its selected line high while an unselected line is also high, with the global enable off, and with its own enable cleared. Together these show which of the three gating terms the count depends on. The cycle counter is run in divide-by-64 mode twice, once from a clean start and once after a mid-window cycle reset, which tells a cleared prescaler from a stale one. Overflow is provoked on an event counter whose interrupt is enabled and on the cycle counter whose interrupt is not, which separates the flag from the interrupt. Writes are made with select out of range, and a neighbouring counter is read afterwards, to show that indirect access cannot alias.

// File: rtl/pmu_pkg.sv
// Shared definitions for the performance counter unit.
// Assumes a 32-bit register bus. The cycle counter owns mask bit 31.
package pmu_pkg;
    localparam int REG_W   = 32;
    localparam int CYC_BIT = 31;

    typedef enum logic [3:0] {
        ADDR_CTRL   = 4'd0,
        ADDR_EN_SET = 4'd1,
        ADDR_EN_CLR = 4'd2,
        ADDR_IE_SET = 4'd3,
        ADDR_IE_CLR = 4'd4,
        ADDR_FLAG   = 4'd5,
        ADDR_SEL    = 4'd6,
        ADDR_EVTYPE = 4'd7,
        ADDR_EVCNT  = 4'd8,
        ADDR_CYCCNT = 4'd9
    } pmu_addr_e;
endpackage

// File: rtl/pmu_regfile.sv
// Holds the control bits, the counter enable mask, the interrupt enable
// mask and the event counter select.
// Assumes mask vectors are packed as {cycle, event[N-1:0]}. The caller
// already converts bus positions into that packing.
module pmu_regfile #(
    parameter int NUM_CNT = 5,
    parameter int SEL_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_ctrl,
    input  logic               wr_en_set,
    input  logic               wr_en_clr,
    input  logic               wr_ie_set,
    input  logic               wr_ie_clr,
    input  logic               wr_sel,
    input  logic [5:0]         ctrl_wdata,
    input  logic [NUM_CNT-1:0] mask_wdata,
    input  logic [SEL_W-1:0]   sel_wdata,
    output logic               glb_en,
    output logic               div64,
    output logic [5:0]         ctrl_rd,
    output logic [NUM_CNT-1:0] cnt_en,
    output logic [NUM_CNT-1:0] int_en,
    output logic [SEL_W-1:0]   sel,
    output logic               ev_clr,
    output logic               cyc_clr
);
    logic [1:0] aux_q;

    // Control register: enable, divider and two plain storage bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_en <= 1'b0;
            div64  <= 1'b0;
            aux_q  <= 2'b00;
        end else if (wr_ctrl) begin
            glb_en <= ctrl_wdata[0];
            div64  <= ctrl_wdata[3];
            aux_q  <= ctrl_wdata[5:4];
        end
    end

    // Reset actions are one-cycle strobes taken straight from the write.
    always_comb begin
        ev_clr  = wr_ctrl & ctrl_wdata[1];
        cyc_clr = wr_ctrl & ctrl_wdata[2];
        ctrl_rd = {aux_q, div64, 2'b00, glb_en};
    end

    // Counter enable mask with separate set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_en <= '0;
        else if (wr_en_set)
            cnt_en <= cnt_en | mask_wdata;
        else if (wr_en_clr)
            cnt_en <= cnt_en & ~mask_wdata;
    end

    // Interrupt enable mask with separate set and clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_en <= '0;
        else if (wr_ie_set)
            int_en <= int_en | mask_wdata;
        else if (wr_ie_clr)
            int_en <= int_en & ~mask_wdata;
    end

    // Event counter select register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= '0;
        else if (wr_sel)
            sel <= sel_wdata;
    end
endmodule

// File: rtl/pmu_event_ctr.sv
// One event counter with its own event type register.
// Assumes the event lines are already synchronous to clk. A clear beats
// a software load, and a software load beats an increment.
module pmu_event_ctr #(
    parameter int CNT_W      = 32,
    parameter int NUM_EVENTS = 128,
    parameter int EVT_W      = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  glb_en,
    input  logic                  cnt_en,
    input  logic [NUM_EVENTS-1:0] events,
    input  logic                  type_wr,
    input  logic [EVT_W-1:0]      type_wdata,
    input  logic                  count_wr,
    input  logic [CNT_W-1:0]      count_wdata,
    input  logic                  clr,
    output logic [EVT_W-1:0]      type_q,
    output logic [CNT_W-1:0]      count_q,
    output logic                  ovf
);
    logic hit;
    logic adv;

    // Advance when both enables are on and the chosen line is high.
    always_comb begin
        hit = events[type_q];
        adv = glb_en & cnt_en & hit;
        ovf = adv & ~clr & ~count_wr & (count_q == {CNT_W{1'b1}});
    end

    // Event type storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            type_q <= '0;
        else if (type_wr)
            type_q <= type_wdata;
    end

    // Count register: clear, load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (clr)
            count_q <= '0;
        else if (count_wr)
            count_q <= count_wdata;
        else if (adv)
            count_q <= count_q + CNT_W'(1);
    end
endmodule

// File: rtl/pmu_cycle_ctr.sv
// Cycle counter with an optional power-of-two prescaler.
// Assumes the prescaler runs only while the counter is enabled and is
// zeroed by the cycle reset action.
module pmu_cycle_ctr #(
    parameter int CNT_W    = 32,
    parameter int DIV_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             glb_en,
    input  logic             cnt_en,
    input  logic             div_on,
    input  logic             count_wr,
    input  logic [CNT_W-1:0] count_wdata,
    input  logic             clr,
    output logic [CNT_W-1:0] count_q,
    output logic             ovf
);
    logic [DIV_LOG2-1:0] pre_q;
    logic                run;
    logic                tick;

    // Step enable, with the prescaler terminal count when dividing.
    always_comb begin
        run  = glb_en & cnt_en;
        tick = run & (~div_on | (pre_q == {DIV_LOG2{1'b1}}));
        ovf  = tick & ~clr & ~count_wr & (count_q == {CNT_W{1'b1}});
    end

    // Prescaler: free-runs while enabled in divide mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr)
            pre_q <= '0;
        else if (run && div_on)
            pre_q <= pre_q + DIV_LOG2'(1);
    end

    // Count register: clear, load, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (clr)
            count_q <= '0;
        else if (count_wr)
            count_q <= count_wdata;
        else if (tick)
            count_q <= count_q + CNT_W'(1);
    end
endmodule

// File: rtl/pmu_monitor.sv
// Top of the performance counter unit: address decode, overflow flags,
// interrupt and read mux.
// Assumes single-cycle register accesses. Read data is combinational
// and valid while bus_en is high and bus_wr is low.
module pmu_monitor
    import pmu_pkg::*;
#(
    parameter int NUM_EV_CNT = 4,
    parameter int NUM_EVENTS = 128,
    parameter int CNT_W      = 32,
    parameter int SEL_W      = 5,
    parameter int DIV_LOG2   = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_en,
    input  logic                  bus_wr,
    input  logic [3:0]            bus_addr,
    input  logic [REG_W-1:0]      bus_wdata,
    output logic [REG_W-1:0]      bus_rdata,
    input  logic [NUM_EVENTS-1:0] event_in,
    output logic                  irq
);
    localparam int NUM_CNT = NUM_EV_CNT + 1;
    localparam int EVT_W   = $clog2(NUM_EVENTS);
    localparam int IDX_W   = (NUM_EV_CNT > 1) ? $clog2(NUM_EV_CNT) : 1;

    logic                 wr;
    logic                 wr_ctrl, wr_en_set, wr_en_clr, wr_ie_set, wr_ie_clr;
    logic                 wr_sel, wr_flag, wr_type, wr_evcnt, wr_cyc;
    logic [NUM_CNT-1:0]   mask_w;
    logic                 glb_en, div64, ev_clr, cyc_clr;
    logic [5:0]           ctrl_rd;
    logic [NUM_CNT-1:0]   cnt_en, int_en;
    logic [SEL_W-1:0]     sel;
    logic                 sel_ok;
    logic [IDX_W-1:0]     sel_idx;
    logic [EVT_W-1:0]     ev_type  [NUM_EV_CNT];
    logic [CNT_W-1:0]     ev_count [NUM_EV_CNT];
    logic [NUM_EV_CNT-1:0] ev_ovf;
    logic [CNT_W-1:0]     cyc_count;
    logic                 cyc_ovf;
    logic [NUM_CNT-1:0]   flag_q;
    logic [REG_W-1:0]     rd_mux;

    // Turns a packed {cycle, events} mask into bus bit positions.
    function automatic logic [REG_W-1:0] to_bus(input logic [NUM_CNT-1:0] v);
        logic [REG_W-1:0] r;
        r = '0;
        r[CYC_BIT] = v[NUM_EV_CNT];
        r[NUM_EV_CNT-1:0] = v[NUM_EV_CNT-1:0];
        return r;
    endfunction

    // Address decode for writes and the packed write mask.
    always_comb begin
        wr        = bus_en & bus_wr;
        wr_ctrl   = wr & (bus_addr == ADDR_CTRL);
        wr_en_set = wr & (bus_addr == ADDR_EN_SET);
        wr_en_clr = wr & (bus_addr == ADDR_EN_CLR);
        wr_ie_set = wr & (bus_addr == ADDR_IE_SET);
        wr_ie_clr = wr & (bus_addr == ADDR_IE_CLR);
        wr_flag   = wr & (bus_addr == ADDR_FLAG);
        wr_sel    = wr & (bus_addr == ADDR_SEL);
        wr_type   = wr & (bus_addr == ADDR_EVTYPE);
        wr_evcnt  = wr & (bus_addr == ADDR_EVCNT);
        wr_cyc    = wr & (bus_addr == ADDR_CYCCNT);
        mask_w    = {bus_wdata[CYC_BIT], bus_wdata[NUM_EV_CNT-1:0]};
        sel_ok    = (sel < SEL_W'(NUM_EV_CNT));
        sel_idx   = sel[IDX_W-1:0];
    end

    pmu_regfile #(
        .NUM_CNT (NUM_CNT),
        .SEL_W   (SEL_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (wr_ctrl),
        .wr_en_set  (wr_en_set),
        .wr_en_clr  (wr_en_clr),
        .wr_ie_set  (wr_ie_set),
        .wr_ie_clr  (wr_ie_clr),
        .wr_sel     (wr_sel),
        .ctrl_wdata (bus_wdata[5:0]),
        .mask_wdata (mask_w),
        .sel_wdata  (bus_wdata[SEL_W-1:0]),
        .glb_en     (glb_en),
        .div64      (div64),
        .ctrl_rd    (ctrl_rd),
        .cnt_en     (cnt_en),
        .int_en     (int_en),
        .sel        (sel),
        .ev_clr     (ev_clr),
        .cyc_clr    (cyc_clr)
    );

    for (genvar i = 0; i < NUM_EV_CNT; i++) begin : g_ev
        logic hit_sel;
        assign hit_sel = sel_ok && (sel_idx == IDX_W'(i));

        pmu_event_ctr #(
            .CNT_W      (CNT_W),
            .NUM_EVENTS (NUM_EVENTS),
            .EVT_W      (EVT_W)
        ) u_ctr (
            .clk         (clk),
            .rst_n       (rst_n),
            .glb_en      (glb_en),
            .cnt_en      (cnt_en[i]),
            .events      (event_in),
            .type_wr     (wr_type & hit_sel),
            .type_wdata  (bus_wdata[EVT_W-1:0]),
            .count_wr    (wr_evcnt & hit_sel),
            .count_wdata (bus_wdata[CNT_W-1:0]),
            .clr         (ev_clr),
            .type_q      (ev_type[i]),
            .count_q     (ev_count[i]),
            .ovf         (ev_ovf[i])
        );
    end

    pmu_cycle_ctr #(
        .CNT_W    (CNT_W),
        .DIV_LOG2 (DIV_LOG2)
    ) u_cyc (
        .clk         (clk),
        .rst_n       (rst_n),
        .glb_en      (glb_en),
        .cnt_en      (cnt_en[NUM_EV_CNT]),
        .div_on      (div64),
        .count_wr    (wr_cyc),
        .count_wdata (bus_wdata[CNT_W-1:0]),
        .clr         (cyc_clr),
        .count_q     (cyc_count),
        .ovf         (cyc_ovf)
    );

    // Sticky overflow flags; a new overflow wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= '0;
        else
            flag_q <= (flag_q & ~(wr_flag ? mask_w : '0)) | {cyc_ovf, ev_ovf};
    end

    // Level interrupt from enabled flags.
    always_comb irq = |(flag_q & int_en);

    // Read data selection.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_CTRL:   rd_mux = REG_W'(ctrl_rd);
            ADDR_EN_SET,
            ADDR_EN_CLR: rd_mux = to_bus(cnt_en);
            ADDR_IE_SET,
            ADDR_IE_CLR: rd_mux = to_bus(int_en);
            ADDR_FLAG:   rd_mux = to_bus(flag_q);
            ADDR_SEL:    rd_mux = REG_W'(sel);
            ADDR_EVTYPE: rd_mux = sel_ok ? REG_W'(ev_type[sel_idx]) : '0;
            ADDR_EVCNT:  rd_mux = sel_ok ? REG_W'(ev_count[sel_idx]) : '0;
            ADDR_CYCCNT: rd_mux = REG_W'(cyc_count);
            default:     rd_mux = '0;
        endcase
        bus_rdata = (bus_en && !bus_wr) ? rd_mux : '0;
    end
endmodule

// File: rtl/pmu_monitor_chk.sv
// Property checker for the performance counter unit, bound to the top.
// Assumes it sees the top's flag vector, global enable and cycle count.
module pmu_monitor_chk
    import pmu_pkg::*;
#(
    parameter int NUM_EV_CNT = 4,
    parameter int CNT_W      = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_en,
    input logic                  bus_wr,
    input logic [3:0]            bus_addr,
    input logic [REG_W-1:0]      bus_rdata,
    input logic                  irq,
    input logic                  glb_en,
    input logic [NUM_EV_CNT:0]   flags,
    input logic [CNT_W-1:0]      cyc_count
);
    logic any_wr;
    logic flag_wr;
    logic rd;
    logic mask_rd;

    always_comb begin
        any_wr  = bus_en & bus_wr;
        flag_wr = any_wr & (bus_addr == ADDR_FLAG);
        rd      = bus_en & ~bus_wr;
        mask_rd = rd & (bus_addr >= ADDR_EN_SET) & (bus_addr <= ADDR_FLAG);
    end

    // R3: with the global enable off and no write, the cycle count holds.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !any_wr) |=> $stable(cyc_count));

    // R7: without a flag write no set flag can drop.
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flags & $past(flags)) == $past(flags)));

    // R8: the interrupt needs at least one flag.
    a_r8_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags != '0));

    // R2: action bits and upper control bits never read as 1.
    a_r2_ctrl_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && bus_addr == ADDR_CTRL) |-> (bus_rdata[2:1] == 2'b00 && bus_rdata[31:6] == '0));

    // R4: unused mask positions read as zero.
    a_r4_mask_read: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rd |-> (bus_rdata[30:NUM_EV_CNT] == '0));
endmodule

bind pmu_monitor pmu_monitor_chk #(
    .NUM_EV_CNT (NUM_EV_CNT),
    .CNT_W      (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .glb_en    (glb_en),
    .flags     (flag_q),
    .cyc_count (cyc_count)
);

// File: tb/sim_pmu_monitor.sv
// Directed bench for the performance counter unit.
module sim_pmu_monitor;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_en = 1'b0;
    logic         bus_wr = 1'b0;
    logic [3:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic [127:0] event_in = '0;
    logic         irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2,
        A_IES = 4'd3, A_IEC = 4'd4, A_FLG = 4'd5, A_SEL = 4'd6,
        A_TYP = 4'd7, A_EVC = 4'd8, A_CYC = 4'd9;

    always #4 clk = ~clk;

    pmu_monitor u0 (
        .clk (clk), .rst_n (rst_n), .bus_en (bus_en), .bus_wr (bus_wr),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .event_in (event_in), .irq (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_en = 1'b0;
    endtask

    task automatic t_reset;
        for (int a = 0; a < 10; a++) rd_chk("R1", 4'(a), 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl;
        wr(A_CTRL, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl mask", A_CTRL, 32'h0000_0039);
        wr(A_CTRL, 32'h0);
        rd_chk("R2 ctrl zero", A_CTRL, 32'h0);
    endtask

    task automatic t_enables;
        wr(A_ENS, 32'h7FFF_FFF0);
        rd_chk("R4 unused bits", A_ENS, 32'h0);
        wr(A_ENS, 32'h8000_0005);
        rd_chk("R4 set", A_ENS, 32'h8000_0005);
        rd_chk("R4 clr addr read", A_ENC, 32'h8000_0005);
        wr(A_ENC, 32'h0);
        rd_chk("R4 zero clr", A_ENS, 32'h8000_0005);
        wr(A_ENC, 32'h8000_0001);
        rd_chk("R4 clr", A_ENS, 32'h0000_0004);
        wr(A_ENC, 32'h4);
        rd_chk("R4 all clr", A_ENS, 32'h0);
        wr(A_IES, 32'hFFFF_FFFF);
        rd_chk("R8 ie set", A_IES, 32'h8000_000F);
        wr(A_IEC, 32'h0000_000F);
        rd_chk("R8 ie clr", A_IEC, 32'h8000_0000);
        wr(A_IEC, 32'h8000_0000);
        rd_chk("R8 ie none", A_IES, 32'h0);
    endtask

    task automatic t_event_count;
        wr(A_SEL, 32'h0);
        wr(A_TYP, 32'h3);
        rd_chk("R9 type", A_TYP, 32'h3);
        wr(A_ENS, 32'h1);
        event_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        event_in[3] = 1'b0;
        rd_chk("R3 global off", A_EVC, 32'h0);
        wr(A_CTRL, 32'h1);
        event_in[4] = 1'b1;
        event_in[3] = 1'b1;
        repeat (5) @(negedge clk);
        event_in[3] = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk("R3 count", A_EVC, 32'h5);
        wr(A_ENC, 32'h1);
        event_in[3] = 1'b1;
        repeat (4) @(negedge clk);
        event_in[3] = 1'b0;
        event_in[4] = 1'b0;
        rd_chk("R4 disabled hold", A_EVC, 32'h5);
        wr(A_CTRL, 32'h0);
    endtask

    task automatic t_reset_bits;
        wr(A_CYC, 32'h0000_1234);
        wr(A_CTRL, 32'h2);
        rd_chk("R5 event clr", A_EVC, 32'h0);
        rd_chk("R5 cycle kept", A_CYC, 32'h0000_1234);
        rd_chk("R2 pulse reads 0", A_CTRL, 32'h0);
        wr(A_CTRL, 32'h4);
        rd_chk("R5 cycle clr", A_CYC, 32'h0);
    endtask

    task automatic t_cycle_div;
        wr(A_ENS, 32'h8000_0000);
        wr(A_CTRL, 32'h9);
        repeat (63) @(negedge clk);
        rd_chk("R6 before 64", A_CYC, 32'h0);
        @(negedge clk);
        rd_chk("R6 at 64", A_CYC, 32'h1);
        repeat (20) @(negedge clk);
        wr(A_CTRL, 32'hD);
        rd_chk("R5 clr in div", A_CYC, 32'h0);
        repeat (63) @(negedge clk);
        rd_chk("R5 prescaler cleared", A_CYC, 32'h0);
        @(negedge clk);
        rd_chk("R6 after clr", A_CYC, 32'h1);
        wr(A_CTRL, 32'h0);
        wr(A_ENC, 32'h8000_0000);
        wr(A_CTRL, 32'h4);
    endtask

    task automatic t_overflow;
        wr(A_IES, 32'h4);
        wr(A_SEL, 32'h2);
        wr(A_TYP, 32'h5);
        wr(A_EVC, 32'hFFFF_FFFE);
        wr(A_ENS, 32'h4);
        wr(A_CTRL, 32'h1);
        event_in[5] = 1'b1;
        @(negedge clk);
        rd_chk("R7 no flag yet", A_FLG, 32'h0);
        check("R8 irq low", {31'b0, irq}, 32'h0);
        @(negedge clk);
        event_in[5] = 1'b0;
        rd_chk("R7 wrap", A_EVC, 32'h0);
        rd_chk("R7 flag", A_FLG, 32'h4);
        check("R8 irq high", {31'b0, irq}, 32'h1);
        wr(A_FLG, 32'h0);
        rd_chk("R7 zero write", A_FLG, 32'h4);
        wr(A_IEC, 32'h4);
        check("R8 ie off", {31'b0, irq}, 32'h0);
        wr(A_IES, 32'h4);
        check("R8 ie on", {31'b0, irq}, 32'h1);
        wr(A_FLG, 32'h4);
        rd_chk("R7 w1c", A_FLG, 32'h0);
        check("R8 irq cleared", {31'b0, irq}, 32'h0);
        wr(A_CYC, 32'hFFFF_FFFF);
        wr(A_ENS, 32'h8000_0000);
        @(negedge clk);
        rd_chk("R7 cycle wrap", A_CYC, 32'h0);
        rd_chk("R7 cycle flag", A_FLG, 32'h8000_0000);
        check("R8 not enabled", {31'b0, irq}, 32'h0);
        wr(A_CTRL, 32'h0);
        wr(A_ENC, 32'h8000_000F);
        wr(A_FLG, 32'hFFFF_FFFF);
        rd_chk("R7 all clr", A_FLG, 32'h0);
    endtask

    task automatic t_select;
        wr(A_SEL, 32'h27);
        rd_chk("R9 sel mask", A_SEL, 32'h7);
        wr(A_TYP, 32'h11);
        wr(A_EVC, 32'hABCD);
        rd_chk("R9 type oob", A_TYP, 32'h0);
        rd_chk("R9 count oob", A_EVC, 32'h0);
        wr(A_SEL, 32'h3);
        rd_chk("R9 no alias type", A_TYP, 32'h0);
        rd_chk("R9 no alias count", A_EVC, 32'h0);
        wr(A_SEL, 32'h1);
        wr(A_TYP, 32'hFF);
        rd_chk("R9 type mask", A_TYP, 32'h7F);
        wr(A_EVC, 32'h55);
        rd_chk("R9 count sel1", A_EVC, 32'h55);
        wr(A_SEL, 32'h2);
        rd_chk("R9 other ctr", A_EVC, 32'h0);
    endtask

    task automatic t_cycle_direct;
        wr(A_SEL, 32'h1);
        wr(A_CYC, 32'hCAFE_0000);
        repeat (3) @(negedge clk);
        rd_chk("R10 direct", A_CYC, 32'hCAFE_0000);
        rd_chk("R10 sel untouched", A_EVC, 32'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_enables();
        t_event_count();
        t_reset_bits();
        t_cycle_div();
        t_overflow();
        t_select();
        t_cycle_direct();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule